// File: doc/BRIEF.md
# Reserved Address Reset and ID Handler

This block runs next to an I2C slave byte engine and takes care of the two reserved addresses that ordinary slave decoding does not cover. The engine reports decoded bus events to it: a START, a repeated START, a STOP, each received byte, and the master's ACK or NACK after each byte the slave sends. The handler then returns an acknowledge decision for every received byte, supplies the byte to send while a device-ID readback is running, and emits a one-clock soft reset pulse. That pulse drives the synchronous reset of the port and interrupt logic of the expander.

There are two reserved sequences. The first is a general-call reset. The master sends address byte 00h, then command 06h, then STOP, and the reset fires on the STOP. The second is an identity readback. The master sends address 1111100 in write mode, followed by the 7-bit address of the slave it wants to identify. It then issues a repeated START and sends 1111100 again, this time in read mode. From that point the handler streams a 24-bit identity (manufacturer, category, feature, revision) for as long as the master keeps acknowledging.

The controller is a single enumerated state machine with these states:
- `S_IDLE`: no reserved transfer is in progress.
- `S_ADDR`: the next byte is an address byte.
- `S_GC_CMD`: a general call was accepted.
- `S_GC_ARMED`: the 06h command was accepted.
- `S_GC_DEAD`: the general call was rejected; every byte is refused until the next START or STOP.
- `S_ID_TGT`: the next byte names the target of the identity query.
- `S_ID_WAIT`: the target matched and the handler waits for a repeated START.
- `S_ID_RADDR`: the address byte after that repeated START is expected.
- `S_ID_SEND`: identity bytes are being streamed.

Transitions:
- A STOP leads to `S_IDLE` from any state. It fires the reset if the state is `S_GC_ARMED`.
- A repeated START in `S_ID_WAIT` leads to `S_ID_RADDR`.
- Any other START or repeated START leads to `S_ADDR`.
- In `S_ADDR` and `S_ID_RADDR`:
  - 00h leads to `S_GC_CMD`.
  - F8h leads to `S_ID_TGT`.
  - F9h leads to `S_ID_SEND`, but only from `S_ID_RADDR`.
  - Any other byte leads to `S_IDLE`.
- In `S_GC_CMD`, 06h leads to `S_GC_ARMED` and any other byte leads to `S_GC_DEAD`.
- In `S_GC_ARMED`, any further byte leads to `S_GC_DEAD`.
- In `S_ID_TGT`, a matching target leads to `S_ID_WAIT` and a mismatch leads to `S_IDLE`.
- In `S_ID_WAIT`, a received byte leads to `S_IDLE`.
- In `S_ID_SEND`, a master NACK leads to `S_IDLE`.

Top module: `resv_addr_handler`

## Requirements
- R1: As an address byte, 00h is acknowledged, 01h (general call with the read bit) is not, and every byte other than 00h and F8h is not acknowledged. On `ack_bit`, 1 means ACK and 0 means NACK.
- R2: After an accepted general call, only the data byte 06h is acknowledged. Any other value, and any byte that follows an accepted 06h, is not acknowledged.
- R3: `soft_rst` is high for exactly one clock, one cycle after a STOP that directly follows an acknowledged 06h. In every other case it stays low.
- R4: A repeated START after an acknowledged 06h cancels the reset, so a later STOP produces no pulse.
- R5: Address byte F8h (1111100, write) is acknowledged. The next byte is acknowledged only when its bits [7:1] equal `own_addr`; its bit 0 is ignored.
- R6: After a matched target byte, a repeated START and then F9h are acknowledged. `tx_valid` rises together with that acknowledge, and `tx_byte` then shows identity bits [23:16].
- R7: Any of the following discards the identity state, so that a later F9h is not acknowledged and `tx_valid` stays low: a STOP in place of the repeated START, an address byte other than F9h after the repeated START, or a mismatched target byte.
- R8: Each master ACK during readback advances `tx_byte` through bits [23:16], [15:8] and [7:0], then wraps back to [23:16]. A master NACK or a STOP drops `tx_valid` on the next cycle.
- R9: F9h as an address byte without the preceding handshake is not acknowledged.
- R10: `ack_valid` pulses for one cycle exactly one cycle after every `rx_valid`, and `ack_bit` holds the decision in that same cycle. After reset, `ack_valid`, `tx_valid` and `soft_rst` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START seen (single-cycle strobe) |
| ev_rstart | input | 1 | Repeated START seen (single-cycle strobe) |
| ev_stop | input | 1 | STOP seen (single-cycle strobe) |
| rx_valid | input | 1 | A byte was received |
| rx_byte | input | 8 | The received byte |
| mst_ack | input | 1 | Master acknowledged the byte just sent |
| mst_nack | input | 1 | Master did not acknowledge the byte just sent |
| own_addr | input | 7 | This device's 7-bit slave address |
| ack_valid | output | 1 | Acknowledge decision is present |
| ack_bit | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Identity readback is active |
| tx_byte | output | 8 | Identity byte to transmit |
| soft_rst | output | 1 | One-cycle reset pulse |

## Verification
The hardest condition to reach from the ports is identity output after a complete and legal two-phase handshake, followed by several wraps of the three-byte stream. The bench builds that exact event chain and then performs seven master acknowledges in a row. The bench also drives each of the three ways the handshake can be broken, and checks that a following F9h is refused. Full 256-value sweeps cover the address byte, the general-call data byte and the target byte. The expected acknowledge and reset results are computed arithmetically from each swept value.

// File: rtl/rah_pkg.sv
package rah_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_GC_CMD,
        S_GC_ARMED,
        S_GC_DEAD,
        S_ID_TGT,
        S_ID_WAIT,
        S_ID_RADDR,
        S_ID_SEND
    } rah_state_e;

    localparam logic [7:0] GC_WRITE_BYTE = 8'h00;
    localparam logic [7:0] RESET_CMD     = 8'h06;
    localparam logic [6:0] ID_RESV_ADDR  = 7'b1111100;

endpackage

// File: rtl/rah_id_sel.sv
module rah_id_sel #(
    parameter int                 ID_BITS  = 24,
    parameter logic [ID_BITS-1:0] ID_VALUE = '0,
    parameter int                 NB       = ID_BITS / 8,
    parameter int                 IDX_W    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);

    logic [7:0] slices [NB];

    // Byte 0 holds the most significant bits of the identity.
    for (genvar g = 0; g < NB; g++) begin : g_slice
        assign slices[g] = ID_VALUE[ID_BITS-1-8*g -: 8];
    end

    always_comb begin
        if (32'(idx) < NB) byte_o = slices[idx];
        else               byte_o = 8'h00;
    end

endmodule

// File: rtl/rah_fsm.sv
module rah_fsm
    import rah_pkg::*;
#(
    parameter int NB    = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_rstart,
    input  logic             ev_stop,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             mst_ack,
    input  logic             mst_nack,
    input  logic [6:0]       own_addr,
    output logic             ack_valid,
    output logic             ack_bit,
    output logic             tx_valid,
    output logic [IDX_W-1:0] idx,
    output logic             soft_rst
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);
    localparam logic [7:0] ID_WR_BYTE = {ID_RESV_ADDR, 1'b0};
    localparam logic [7:0] ID_RD_BYTE = {ID_RESV_ADDR, 1'b1};

    rah_state_e       state, nxt_state;
    logic [IDX_W-1:0] nxt_idx;
    logic             nxt_ackv, nxt_ack, nxt_rst;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    // Output and index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            ack_valid <= 1'b0;
            ack_bit   <= 1'b0;
            soft_rst  <= 1'b0;
        end else begin
            idx       <= nxt_idx;
            ack_valid <= nxt_ackv;
            ack_bit   <= nxt_ack;
            soft_rst  <= nxt_rst;
        end
    end

    assign tx_valid = (state == S_ID_SEND);

    // Next-state and next-output decision
    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        nxt_ackv  = 1'b0;
        nxt_ack   = 1'b0;
        nxt_rst   = 1'b0;
        if (ev_stop) begin
            nxt_rst   = (state == S_GC_ARMED);
            nxt_state = S_IDLE;
        end else if (ev_rstart && state == S_ID_WAIT) begin
            nxt_state = S_ID_RADDR;
        end else if (ev_start || ev_rstart) begin
            nxt_state = S_ADDR;
        end else begin
            nxt_ackv = rx_valid;
            unique case (state)
                S_IDLE: ;
                S_ADDR, S_ID_RADDR: begin
                    if (rx_valid) begin
                        if (state == S_ID_RADDR && rx_byte == ID_RD_BYTE) begin
                            nxt_ack   = 1'b1;
                            nxt_state = S_ID_SEND;
                            nxt_idx   = '0;
                        end else if (rx_byte == GC_WRITE_BYTE) begin
                            nxt_ack   = 1'b1;
                            nxt_state = S_GC_CMD;
                        end else if (rx_byte == ID_WR_BYTE) begin
                            nxt_ack   = 1'b1;
                            nxt_state = S_ID_TGT;
                        end else begin
                            nxt_state = S_IDLE;
                        end
                    end
                end
                S_GC_CMD: begin
                    if (rx_valid) begin
                        if (rx_byte == RESET_CMD) begin
                            nxt_ack   = 1'b1;
                            nxt_state = S_GC_ARMED;
                        end else begin
                            nxt_state = S_GC_DEAD;
                        end
                    end
                end
                S_GC_ARMED: begin
                    if (rx_valid) nxt_state = S_GC_DEAD;
                end
                S_GC_DEAD: ;
                S_ID_TGT: begin
                    if (rx_valid) begin
                        if (rx_byte[7:1] == own_addr) begin
                            nxt_ack   = 1'b1;
                            nxt_state = S_ID_WAIT;
                        end else begin
                            nxt_state = S_IDLE;
                        end
                    end
                end
                S_ID_WAIT: begin
                    if (rx_valid) nxt_state = S_IDLE;
                end
                S_ID_SEND: begin
                    if (mst_ack) begin
                        nxt_idx = (idx == LAST_IDX) ? '0 : idx + 1'b1;
                    end else if (mst_nack) begin
                        nxt_state = S_IDLE;
                    end
                end
            endcase
        end
    end

    // R3
    rst_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> ($past(ev_stop) && $past(state == S_GC_ARMED)));

    // R3
    rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R10
    ack_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    // R5
    tgt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_bit && $past(state == S_ID_TGT))
            |-> ($past(rx_byte[7:1]) == $past(own_addr)));

    // R6
    send_entry_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (ack_valid && ack_bit));

endmodule

// File: rtl/resv_addr_handler.sv
module resv_addr_handler #(
    parameter logic [7:0] MFR_ID    = 8'h00,
    parameter logic [6:0] PART_CAT  = 7'h25,
    parameter logic [5:0] PART_FEAT = 6'h0B,
    parameter logic [2:0] DIE_REV   = 3'h2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_rstart,
    input  logic       ev_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       mst_ack,
    input  logic       mst_nack,
    input  logic [6:0] own_addr,
    output logic       ack_valid,
    output logic       ack_bit,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       soft_rst
);

    localparam int ID_BITS = 24;
    localparam int NB      = ID_BITS / 8;
    localparam int IDX_W   = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [ID_BITS-1:0] ID_VALUE = {MFR_ID, PART_CAT, PART_FEAT, DIE_REV};

    logic [IDX_W-1:0] idx;

    rah_fsm #(.NB(NB), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (ev_start),
        .ev_rstart (ev_rstart),
        .ev_stop   (ev_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .mst_ack   (mst_ack),
        .mst_nack  (mst_nack),
        .own_addr  (own_addr),
        .ack_valid (ack_valid),
        .ack_bit   (ack_bit),
        .tx_valid  (tx_valid),
        .idx       (idx),
        .soft_rst  (soft_rst)
    );

    rah_id_sel #(.ID_BITS(ID_BITS), .ID_VALUE(ID_VALUE), .NB(NB), .IDX_W(IDX_W)) u_idsel (
        .idx    (idx),
        .byte_o (tx_byte)
    );

endmodule

// File: tb/sim_resv_addr_handler.sv
module sim_resv_addr_handler;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] T_MFR  = 8'h00;
    localparam logic [6:0] T_CAT  = 7'h25;
    localparam logic [5:0] T_FEAT = 6'h0B;
    localparam logic [2:0] T_REV  = 3'h2;
    localparam logic [6:0] OWN    = 7'h2C;
    localparam logic [23:0] EXP_ID = {T_MFR, T_CAT, T_FEAT, T_REV};

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_rstart = 0, ev_stop = 0, rx_valid = 0, mst_ack = 0, mst_nack = 0;
    logic [7:0] rx_byte = 8'h00;
    logic [6:0] own_addr = OWN;
    logic ack_valid, ack_bit, tx_valid, soft_rst;
    logic [7:0] tx_byte;

    int tests = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_addr_handler #(.MFR_ID(T_MFR), .PART_CAT(T_CAT), .PART_FEAT(T_FEAT), .DIE_REV(T_REV)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .mst_ack(mst_ack), .mst_nack(mst_nack),
        .own_addr(own_addr), .ack_valid(ack_valid), .ack_bit(ack_bit), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .soft_rst(soft_rst)
    );

    function automatic logic [7:0] id_byte(int k);
        return EXP_ID[23-8*k -: 8];
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) ev_start = 1;
        @(negedge clk) ev_start = 0;
    endtask

    task automatic do_rstart();
        @(negedge clk) ev_rstart = 1;
        @(negedge clk) ev_rstart = 0;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic v, output logic a);
        @(negedge clk) begin rx_valid = 1; rx_byte = b; end
        @(negedge clk) rx_valid = 0;
        v = ack_valid;
        a = ack_bit;
    endtask

    task automatic do_stop(output logic p1, output logic p2);
        @(negedge clk) ev_stop = 1;
        @(negedge clk) ev_stop = 0;
        p1 = soft_rst;
        @(negedge clk) p2 = soft_rst;
    endtask

    task automatic m_resp(input logic ackit);
        @(negedge clk) if (ackit) mst_ack = 1; else mst_nack = 1;
        @(negedge clk) begin mst_ack = 0; mst_nack = 0; end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic v, a, p1, p2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset ack_valid", int'(ack_valid), 0);
        chk("R10 reset tx_valid", int'(tx_valid), 0);
        chk("R10 reset soft_rst", int'(soft_rst), 0);

        // R1 / R9 / R10: every address byte
        for (int b = 0; b < 256; b++) begin
            do_start();
            put_byte(8'(b), v, a);
            chk("R10 ack_valid after byte", int'(v), 1);
            chk((b == 8'hF9) ? "R9 lone F9h" : "R1 address ack", int'(a),
                (b == 0 || b == 8'hF8) ? 1 : 0);
            do_stop(p1, p2);
            chk("R3 no reset without command", int'(p1), 0);
        end

        // R2 / R3: every general-call data byte
        for (int d = 0; d < 256; d++) begin
            do_start();
            put_byte(8'h00, v, a);
            put_byte(8'(d), v, a);
            chk("R2 command ack", int'(a), (d == 6) ? 1 : 0);
            do_stop(p1, p2);
            chk("R3 reset pulse", int'(p1), (d == 6) ? 1 : 0);
            chk("R3 pulse width", int'(p2), 0);
        end

        // R2: a byte after an accepted 06h is refused and disarms the reset
        do_start();
        put_byte(8'h00, v, a);
        put_byte(8'h06, v, a);
        put_byte(8'h06, v, a);
        chk("R2 extra byte nack", int'(a), 0);
        do_stop(p1, p2);
        chk("R3 no reset after extra byte", int'(p1), 0);

        // R4: repeated START cancels the reset
        do_start();
        put_byte(8'h00, v, a);
        put_byte(8'h06, v, a);
        do_rstart();
        do_stop(p1, p2);
        chk("R4 rstart cancels reset", int'(p1 | p2), 0);

        // R5: target byte sweep
        for (int t = 0; t < 256; t++) begin
            do_start();
            put_byte(8'hF8, v, a);
            chk("R5 F8h ack", int'(a), 1);
            put_byte(8'(t), v, a);
            chk("R5 target match", int'(a), (t[7:1] == OWN) ? 1 : 0);
            do_stop(p1, p2);
        end

        // R6 / R8: full readback with wraps, target LSB set
        do_start();
        put_byte(8'hF8, v, a);
        put_byte({OWN, 1'b1}, v, a);
        chk("R5 target lsb ignored", int'(a), 1);
        do_rstart();
        put_byte(8'hF9, v, a);
        chk("R6 F9h ack", int'(a), 1);
        chk("R6 tx_valid", int'(tx_valid), 1);
        chk("R6 first byte", int'(tx_byte), int'(id_byte(0)));
        for (int k = 1; k <= 7; k++) begin
            m_resp(1'b1);
            chk("R8 wrap sequence", int'(tx_byte), int'(id_byte(k % 3)));
            chk("R8 still sending", int'(tx_valid), 1);
        end
        m_resp(1'b0);
        chk("R8 nack ends", int'(tx_valid), 0);
        do_stop(p1, p2);

        // R8: STOP during readback
        do_start();
        put_byte(8'hF8, v, a);
        put_byte({OWN, 1'b0}, v, a);
        do_rstart();
        put_byte(8'hF9, v, a);
        m_resp(1'b1);
        do_stop(p1, p2);
        chk("R8 stop ends", int'(tx_valid), 0);

        // R7: STOP in place of repeated START
        do_start();
        put_byte(8'hF8, v, a);
        put_byte({OWN, 1'b0}, v, a);
        do_stop(p1, p2);
        do_start();
        put_byte(8'hF9, v, a);
        chk("R7 stop discards", int'(a), 0);
        chk("R7 stop discards tx", int'(tx_valid), 0);
        do_stop(p1, p2);

        // R7: other device addressed after repeated START
        do_start();
        put_byte(8'hF8, v, a);
        put_byte({OWN, 1'b0}, v, a);
        do_rstart();
        put_byte(8'h40, v, a);
        chk("R7 other device nack", int'(a), 0);
        do_rstart();
        put_byte(8'hF9, v, a);
        chk("R7 other device discards", int'(a), 0);
        chk("R7 other device tx", int'(tx_valid), 0);
        do_stop(p1, p2);

        // R7: mismatched target
        do_start();
        put_byte(8'hF8, v, a);
        put_byte({OWN ^ 7'h01, 1'b0}, v, a);
        do_rstart();
        put_byte(8'hF9, v, a);
        chk("R7 mismatch discards", int'(a), 0);
        chk("R7 mismatch tx", int'(tx_valid), 0);
        do_stop(p1, p2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule